// File: doc/BRIEF.md
# Weighted 3x3 Contour Classifier

This block takes a raster-order stream of single-bit boundary pixels and classifies each pixel by the local shape of the contour through it. For every pixel it forms a weighted sum over its 3x3 neighbourhood. Each diagonal neighbour weighs 10, each side neighbour weighs 2 and the pixel itself weighs 1. The weights are chosen so that each local contour shape yields its own sum. The sum is then decoded by set membership into one of three contribution classes: a straight link, a diagonal link, or a mixed straight/diagonal link. Any sum outside these sets means no contribution.

The block keeps the two previous image lines in its own buffer, so each pixel is supplied only once. The source may pause at any time by holding the valid input low. After the last pixel of a frame, the block emits the rest of the frame by itself. The source must then stay idle for at least `IMG_W+1` cycles before it starts the next frame. Each output carries a one-hot class code with a valid flag, and the raw 6-bit sum for debug. Line width and frame height are parameters.

Top module: `contour_classifier`

## Requirements
- R1: For each pixel the block reports `sum_o` = 10 x (set diagonal neighbours) + 2 x (set side neighbours) + 1 x (centre). The largest possible value is 49.
- R2: Neighbours that fall outside the image (above row 0, below the last row, left of column 0, right of the last column) count as 0.
- R3: A sum of 5, 7, 15, 17, 25 or 27 gives `cat_o` = 3'b001 (straight link, bit 0).
- R4: A sum of 21 or 33 gives `cat_o` = 3'b010 (diagonal link, bit 1).
- R5: A sum of 13 or 23 gives `cat_o` = 3'b100 (mixed link, bit 2).
- R6: Any other sum gives `cat_o` = 3'b000.
- R7: `cat_o` never has more than one bit set. `cat_o` and `sum_o` are both 0 in every cycle where `valid_o` is low.
- R8: A pixel is taken only in cycles where `pix_valid_i` is high, so idle gaps change no result. Each frame yields exactly `IMG_W*IMG_H` valid outputs, in raster order.
- R9: After the last pixel of a frame, all remaining outputs of that frame appear within `IMG_W+3` cycles, with no further input.
- R10: While reset is held, and after it until the first output, `valid_o`, `cat_o` and `sum_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel present on `pix_i` this cycle |
| pix_i | input | 1 | Boundary pixel, raster order |
| valid_o | output | 1 | Result present for the next pixel in raster order |
| cat_o | output | 3 | One-hot class: bit0 straight, bit1 diagonal, bit2 mixed |
| sum_o | output | 6 | Raw weighted neighbourhood sum |

## Verification
The bench builds the block with a 5x5 frame. At that size every one of the 512 possible 3x3 neighbourhoods can be placed around an interior pixel, one frame each. This reaches every sum the kernel can produce and every class decision. The rest of each 5x5 frame then lands its neighbourhoods against all four borders and the corners. Randomly filled frames with random idle gaps exercise the border masking on dense content, stalls in the middle of a line, and the self-timed completion after the last pixel.

// File: rtl/contour_cls_pkg.sv
package contour_cls_pkg;

  localparam int SUM_W = 6;
  localparam int CAT_W = 3;
  localparam int LUT_N = 1 << SUM_W;

  localparam logic [SUM_W-1:0] WT_CORNER = 6'd10;
  localparam logic [SUM_W-1:0] WT_SIDE   = 6'd2;
  localparam logic [SUM_W-1:0] WT_CENTRE = 6'd1;

  // one vertical slice of the 3x3 window
  typedef struct packed {
    logic up;
    logic mid;
    logic dn;
  } col_t;

  // class bit positions inside cat_o
  localparam int CAT_STRAIGHT = 0;
  localparam int CAT_DIAG     = 1;
  localparam int CAT_MIXED    = 2;

  function automatic logic [CAT_W-1:0] sum_to_cat(input int s);
    logic [CAT_W-1:0] c;
    c = '0;
    case (s)
      5, 7, 15, 17, 25, 27: c[CAT_STRAIGHT] = 1'b1;
      21, 33:               c[CAT_DIAG]     = 1'b1;
      13, 23:               c[CAT_MIXED]    = 1'b1;
      default:              c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/contour_seq.sv
module contour_seq #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int RW = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_valid_i,
  input  logic          pix_i,
  output logic          step_o,
  output logic          pix_o,
  output logic [CW-1:0] col_o,
  output logic          emit_o,
  output logic          top_o,
  output logic          bot_o,
  output logic          left_o,
  output logic          right_o
);

  localparam int NPIX  = IMG_W * IMG_H;
  localparam int NSTEP = NPIX + IMG_W + 1;  // real pixels plus flush steps
  localparam int KW    = $clog2(NSTEP);

  logic [KW-1:0] kc_q;
  logic [CW-1:0] col_q, mc_q;
  logic [RW-1:0] mr_q;
  logic          flush_w, step_w, emit_w;

  assign flush_w = kc_q >= KW'(NPIX);
  assign step_w  = flush_w | pix_valid_i;
  assign emit_w  = kc_q >= KW'(IMG_W + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kc_q  <= '0;
      col_q <= '0;
      mc_q  <= '0;
      mr_q  <= '0;
    end else if (step_w) begin
      if (kc_q == KW'(NSTEP - 1)) begin
        kc_q  <= '0;
        col_q <= '0;
        mc_q  <= '0;
        mr_q  <= '0;
      end else begin
        kc_q  <= kc_q + KW'(1);
        col_q <= (col_q == CW'(IMG_W - 1)) ? '0 : col_q + CW'(1);
        if (emit_w) begin
          if (mc_q == CW'(IMG_W - 1)) begin
            mc_q <= '0;
            mr_q <= mr_q + RW'(1);
          end else begin
            mc_q <= mc_q + CW'(1);
          end
        end
      end
    end
  end

  assign step_o  = step_w;
  assign pix_o   = flush_w ? 1'b0 : pix_i;
  assign col_o   = col_q;
  assign emit_o  = emit_w;
  assign top_o   = mr_q == '0;
  assign bot_o   = mr_q == RW'(IMG_H - 1);
  assign left_o  = mc_q == '0;
  assign right_o = mc_q == CW'(IMG_W - 1);

  a_r9_flush_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_w |=> (kc_q != $past(kc_q)));

  a_r8_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kc_q <= KW'(NSTEP - 1));

endmodule

// File: rtl/contour_line_buf.sv
module contour_line_buf
  import contour_cls_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          pix_i,
  output col_t          col_o
);

  // lane 0: one line back, lane 1: two lines back
  logic [1:0] mem [DEPTH];
  logic [1:0] rd_w;

  assign rd_w = mem[addr_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= {rd_w[0], pix_i};
  end

  assign col_o = '{up: rd_w[1], mid: rd_w[0], dn: pix_i};

endmodule

// File: rtl/contour_window.sv
module contour_window
  import contour_cls_pkg::*;
#(
  parameter int IMG_W = 64,
  localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             pix_i,
  input  logic [CW-1:0]    col_i,
  input  logic             emit_i,
  input  logic             top_i,
  input  logic             bot_i,
  input  logic             left_i,
  input  logic             right_i,
  output logic             vld_o,
  output logic [SUM_W-1:0] sum_o
);

  col_t new_w;
  col_t c_q [3];  // 0 right, 1 centre, 2 left
  logic top_q, bot_q, left_q, right_q, vld_q;

  contour_line_buf #(.DEPTH(IMG_W)) i_lbuf (
    .clk_i  (clk_i),
    .we_i   (step_i),
    .addr_i (col_i),
    .pix_i  (pix_i),
    .col_o  (new_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) c_q[i] <= '0;
      top_q   <= 1'b0;
      bot_q   <= 1'b0;
      left_q  <= 1'b0;
      right_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= step_i & emit_i;
      if (step_i) begin
        c_q[2]  <= c_q[1];
        c_q[1]  <= c_q[0];
        c_q[0]  <= new_w;
        top_q   <= top_i;
        bot_q   <= bot_i;
        left_q  <= left_i;
        right_q <= right_i;
      end
    end
  end

  // border masking: outside pixels read as 0
  col_t m_w [3];
  always_comb begin
    for (int i = 0; i < 3; i++) begin
      m_w[i].up  = c_q[i].up  & ~top_q;
      m_w[i].mid = c_q[i].mid;
      m_w[i].dn  = c_q[i].dn  & ~bot_q;
    end
    if (right_q) m_w[0] = '0;
    if (left_q)  m_w[2] = '0;
  end

  logic [SUM_W-1:0] n_corner, n_side, n_ctr;
  assign n_corner = SUM_W'(m_w[0].up) + SUM_W'(m_w[0].dn)
                  + SUM_W'(m_w[2].up) + SUM_W'(m_w[2].dn);
  assign n_side   = SUM_W'(m_w[1].up) + SUM_W'(m_w[1].dn)
                  + SUM_W'(m_w[0].mid) + SUM_W'(m_w[2].mid);
  assign n_ctr    = SUM_W'(m_w[1].mid);

  assign sum_o = WT_CORNER * n_corner + WT_SIDE * n_side + WT_CENTRE * n_ctr;
  assign vld_o = vld_q;

endmodule

// File: rtl/contour_cat_lut.sv
module contour_cat_lut
  import contour_cls_pkg::*;
(
  input  logic [SUM_W-1:0] sum_i,
  output logic [CAT_W-1:0] cat_o
);

  logic [CAT_W-1:0] table_w [LUT_N];

  for (genvar v = 0; v < LUT_N; v++) begin : g_ent
    assign table_w[v] = sum_to_cat(v);
  end

  assign cat_o = table_w[sum_i];

endmodule

// File: rtl/contour_classifier.sv
module contour_classifier
  import contour_cls_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pix_valid_i,
  input  logic       pix_i,
  output logic       valid_o,
  output logic [2:0] cat_o,
  output logic [5:0] sum_o
);

  localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  logic          step_w, spix_w, emit_w, top_w, bot_w, left_w, right_w;
  logic [CW-1:0] col_w;
  logic          wvld_w;
  logic [SUM_W-1:0] wsum_w;
  logic [CAT_W-1:0] wcat_w;

  contour_seq #(.IMG_W(IMG_W), .IMG_H(IMG_H)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_valid_i (pix_valid_i),
    .pix_i       (pix_i),
    .step_o      (step_w),
    .pix_o       (spix_w),
    .col_o       (col_w),
    .emit_o      (emit_w),
    .top_o       (top_w),
    .bot_o       (bot_w),
    .left_o      (left_w),
    .right_o     (right_w)
  );

  contour_window #(.IMG_W(IMG_W)) i_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_w),
    .pix_i   (spix_w),
    .col_i   (col_w),
    .emit_i  (emit_w),
    .top_i   (top_w),
    .bot_i   (bot_w),
    .left_i  (left_w),
    .right_i (right_w),
    .vld_o   (wvld_w),
    .sum_o   (wsum_w)
  );

  contour_cat_lut i_lut (
    .sum_i (wsum_w),
    .cat_o (wcat_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cat_o   <= '0;
      sum_o   <= '0;
    end else begin
      valid_o <= wvld_w;
      cat_o   <= wvld_w ? wcat_w : '0;
      sum_o   <= wvld_w ? wsum_w : '0;
    end
  end

  a_r7_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cat_o));

  a_r7_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (cat_o == '0 && sum_o == '0));

  a_r1_sum_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o <= 6'd49);

endmodule

// File: tb/test_contour_classifier.sv
module test_contour_classifier;

  localparam int W  = 5;
  localparam int H  = 5;
  localparam int NP = W * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid_i = 1'b0;
  logic pix_i = 1'b0;
  logic valid_o;
  logic [2:0] cat_o;
  logic [5:0] sum_o;

  always #10 clk = ~clk;  // 50 MHz

  contour_classifier #(.IMG_W(W), .IMG_H(H)) i_contour_classifier (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pix_valid_i (pix_valid_i),
    .pix_i       (pix_i),
    .valid_o     (valid_o),
    .cat_o       (cat_o),
    .sum_o       (sum_o)
  );

  int checks = 0;
  int fails  = 0;
  int out_idx = 0;
  bit done = 1'b0;

  logic       img [H][W];
  int         exp_sum [NP];
  logic [2:0] exp_cat [NP];

  function automatic int px(input int r, input int c);
    if (r < 0 || r >= H || c < 0 || c >= W) return 0;
    return int'(img[r][c]);
  endfunction

  function automatic logic [2:0] cat_of(input int s);
    case (s)
      5, 7, 15, 17, 25, 27: return 3'b001;
      21, 33:               return 3'b010;
      13, 23:               return 3'b100;
      default:              return 3'b000;
    endcase
  endfunction

  function automatic string cat_tag(input logic [2:0] c);
    case (c)
      3'b001:  return "R3";
      3'b010:  return "R4";
      3'b100:  return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compute_exp();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int s;
        s = 10 * (px(r-1,c-1) + px(r-1,c+1) + px(r+1,c-1) + px(r+1,c+1))
          + 2 * (px(r-1,c) + px(r+1,c) + px(r,c-1) + px(r,c+1)) + px(r,c);
        exp_sum[r*W+c] = s;
        exp_cat[r*W+c] = cat_of(s);
      end
  endtask

  // output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        checks++;
        if (out_idx >= NP) begin
          fails++;
          $display("FAIL R8 extra output idx=%0d expected at most %0d", out_idx, NP - 1);
        end else begin
          if (int'(sum_o) != exp_sum[out_idx]) begin
            fails++;
            $display("FAIL R1/R2 pixel %0d sum actual=%0d expected=%0d",
                     out_idx, sum_o, exp_sum[out_idx]);
          end
          checks++;
          if (cat_o != exp_cat[out_idx]) begin
            fails++;
            $display("FAIL %s pixel %0d cat actual=%b expected=%b",
                     cat_tag(exp_cat[out_idx]), out_idx, cat_o, exp_cat[out_idx]);
          end
        end
        checks++;
        if ($countones(cat_o) > 1) begin  // R7
          fails++;
          $display("FAIL R7 cat not one-hot actual=%b expected=at most one bit", cat_o);
        end
        out_idx++;
      end else begin
        checks++;
        if (cat_o != 3'b000 || sum_o != 6'd0) begin  // R7
          fails++;
          $display("FAIL R7 idle outputs actual cat=%b sum=%0d expected=0", cat_o, sum_o);
        end
      end
    end
  end

  task automatic run_frame(input bit gaps);
    compute_exp();
    out_idx = 0;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        if (gaps) begin
          int n;
          n = int'($urandom % 4) - 1;
          for (int g = 0; g < n; g++) begin
            pix_valid_i = 1'b0;
            pix_i = ~img[r][c];  // R8: ignored while not valid
            @(negedge clk);
          end
        end
        pix_valid_i = 1'b1;
        pix_i = img[r][c];
        @(negedge clk);
      end
    pix_valid_i = 1'b0;
    pix_i = 1'b0;
    repeat (W + 3) @(negedge clk);
    #1;
    checks++;
    if (out_idx != NP) begin  // R8, R9
      fails++;
      $display("FAIL R9 outputs after flush actual=%0d expected=%0d", out_idx, NP);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || cat_o !== 3'b000 || sum_o !== 6'd0) begin  // R10
      fails++;
      $display("FAIL R10 in reset actual v=%b cat=%b sum=%0d expected=0", valid_o, cat_o, sum_o);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || cat_o !== 3'b000 || sum_o !== 6'd0) begin  // R10
      fails++;
      $display("FAIL R10 after reset actual v=%b cat=%b sum=%0d expected=0", valid_o, cat_o, sum_o);
    end

    // every 3x3 pattern around the centre pixel (R1, R3-R6); borders hit by neighbours (R2)
    for (int p = 0; p < 512; p++) begin
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) img[r][c] = 1'b0;
      for (int b = 0; b < 9; b++) img[1 + b/3][1 + b%3] = p[b];
      run_frame(p[0] ^ p[4]);
    end

    // dense random frames against all borders, with stalls (R2, R8)
    for (int f = 0; f < 120; f++) begin
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) img[r][c] = ($urandom % 100) < 45;
      run_frame(f[0]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule